// File: doc/BRIEF.md
# Single-Channel Read Burst Demultiplexer

This block sits beside a four-channel sampling converter. The converter holds its results in an internal store that can only be read in a fixed order, one word per read strobe. When the converter's active-low interrupt falls, the block drives chip select low and issues a burst of exactly four read strobes. The strobes are timed from the same clock that drives the converter.

A 2-bit select code chooses one of the four words. While the read whose position matches that code is active, the block raises a one-cycle capture pulse and loads the data bus into a holding register. The result is that one channel is picked out of the sequential burst without any addressed access. The select code is taken once, when the burst starts. After the fourth read the position counter returns to zero and the block waits for the next interrupt edge.

Top module: `chan_pick_demux`

## Requirements
- R1: A falling edge of `irq_n` (high on one rising clock edge, low on the next) starts a burst of exactly 4 active-low strobes on `rd_n`.
- R2: `cs_n` is low from the start of the first strobe until the gap after the fourth strobe ends. `rd_n` is never low while `cs_n` is high, and both are high while idle.
- R3: Each strobe holds `rd_n` low for `LOW_CYC` cycles, and consecutive strobes are separated by `GAP_CYC` cycles with `rd_n` high. The defaults are 1 and 1.
- R4: `latch_en` is high for exactly one cycle per burst: the last low cycle of the strobe whose 0-based position equals `chan_sel`. Code 00 picks the first word (channel 1) and code 11 picks the fourth word (channel 4).
- R5: `cap_data` loads `adc_data` at the rising edge that ends the `latch_en` cycle and otherwise holds its value.
- R6: `chan_sel` is sampled when the burst starts. A change to it during the burst has no effect on which word is captured.
- R7: A falling edge of `irq_n` during a burst is ignored: no extra strobes and no restart. `irq_n` that stays low after a burst does not start a new one.
- R8: The strobe position counter restarts at zero for every burst.
- R9: `rd_n` goes low on the clock edge right after the one where the interrupt fall is first seen. That is one cycle of latency.
- R10: While `rst_n` is low at a rising edge, the outputs become `rd_n`=1, `cs_n`=1, `latch_en`=0 and `cap_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the converter |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_n | input | 1 | Converter end-of-sequence interrupt, active low |
| chan_sel | input | 2 | Index of the word to keep (00 = first) |
| adc_data | input | 12 | Converter data bus |
| rd_n | output | 1 | Read strobe to the converter, active low |
| cs_n | output | 1 | Chip select to the converter, active low |
| latch_en | output | 1 | Capture pulse for the selected word |
| cap_data | output | 12 | Captured word of the selected channel |

## Verification
The bench runs a burst for every select code and gives each bus word a distinct value. If the capture pulse were off by one strobe, the wrong word would land in `cap_data`. The bench injects a second interrupt fall partway through a burst and leaves the interrupt low afterwards. A design that re-armed on the extra fall, or that triggered on level, would produce more than four strobes or a second burst. It also changes the select code mid-burst and runs back-to-back bursts. A select that is not registered, or a counter that is not cleared, would then capture the wrong word. The width of each strobe and each gap is measured, so a timer that is off by one shows up as a width error.

// File: rtl/chan_pick_pkg.sv
// Package: shared phase type and fixed burst length for the read demultiplexer.
package chan_pick_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_GAP  = 2'd2
    } burst_ph_t;

    localparam int BURST_READS = 4;
endpackage

// File: rtl/chan_pick_edge.sv
// Module: chan_pick_edge
// Detects the falling edge of the active-low interrupt.
// Assumes irq_n is already synchronous to clk.
module chan_pick_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    output logic irq_fall
);
    logic irq_q;

    // Remember the previous interrupt level; resets high so reset is not an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b1;
        else        irq_q <= irq_n;
    end

    assign irq_fall = irq_q & ~irq_n;
endmodule

// File: rtl/chan_pick_seq.sv
// Module: chan_pick_seq
// Burst sequencer. On a start pulse it emits NUM_READS strobes, each LOW_CYC
// cycles low with GAP_CYC high cycles after it, and keeps cs_n low for the
// whole burst. It pulses latch_en in the last low cycle of the selected strobe.
// Assumes LOW_CYC >= 1 and GAP_CYC >= 1. Start pulses seen while busy are dropped.
module chan_pick_seq
    import chan_pick_pkg::*;
#(
    parameter int NUM_READS = BURST_READS,
    parameter int LOW_CYC   = 1,
    parameter int GAP_CYC   = 1,
    localparam int SEL_W    = (NUM_READS > 1) ? $clog2(NUM_READS) : 1,
    localparam int MAX_PH   = (LOW_CYC > GAP_CYC) ? LOW_CYC : GAP_CYC,
    localparam int TMR_W    = (MAX_PH > 1) ? $clog2(MAX_PH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEL_W-1:0] sel,
    output logic             rd_n,
    output logic             cs_n,
    output logic             latch_en
);
    localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NUM_READS - 1);
    localparam logic [TMR_W-1:0] LOW_LD   = TMR_W'(LOW_CYC - 1);
    localparam logic [TMR_W-1:0] GAP_LD   = TMR_W'(GAP_CYC - 1);

    burst_ph_t        ph;
    logic [TMR_W-1:0] tmr;
    logic [SEL_W-1:0] idx;
    logic [SEL_W-1:0] sel_q;

    // Phase, timer, strobe position and captured select advance together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= PH_IDLE;
            tmr   <= '0;
            idx   <= '0;
            sel_q <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: if (start) begin
                    ph    <= PH_LOW;
                    tmr   <= LOW_LD;
                    idx   <= '0;
                    sel_q <= sel;
                end
                PH_LOW: begin
                    if (tmr == '0) begin
                        ph  <= PH_GAP;
                        tmr <= GAP_LD;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                PH_GAP: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else if (idx == LAST_IDX) begin
                        ph  <= PH_IDLE;
                        idx <= '0;
                    end else begin
                        ph  <= PH_LOW;
                        tmr <= LOW_LD;
                        idx <= idx + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Strobe and select follow the registered phase; the capture pulse marks the selected strobe.
    always_comb begin
        rd_n     = (ph != PH_LOW);
        cs_n     = (ph == PH_IDLE);
        latch_en = (ph == PH_LOW) && (tmr == '0) && (idx == sel_q);
    end

    assert_rd_inside_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cs_n);

    assert_latch_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |-> !rd_n);

    assert_burst_ends_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_IDLE && $past(ph) == PH_GAP) |-> $past(idx) == LAST_IDX);

    assert_sel_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != PH_IDLE && $past(ph) != PH_IDLE) |-> $stable(sel_q));

    assert_busy_ignores_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_GAP && tmr == '0 && idx != LAST_IDX && start) |=> (ph == PH_LOW && idx != '0));
endmodule

// File: rtl/chan_pick_cap.sv
// Module: chan_pick_cap
// Holding register for the selected word: loads on the capture pulse, else holds.
module chan_pick_cap #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    // Capture the bus on the edge that ends the selected strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

    assert_hold_without_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(rst_n)) |-> $stable(dout));
endmodule

// File: rtl/chan_pick_demux.sv
// Module: chan_pick_demux (top)
// Turns a converter interrupt into a fixed read burst and keeps the one word
// selected by chan_sel. Assumes all inputs are synchronous to clk and the
// converter puts the next stored word on the bus for each read strobe.
module chan_pick_demux #(
    parameter int DATA_W    = 12,
    parameter int NUM_READS = 4,
    parameter int LOW_CYC   = 1,
    parameter int GAP_CYC   = 1,
    localparam int SEL_W    = (NUM_READS > 1) ? $clog2(NUM_READS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_n,
    input  logic [SEL_W-1:0]  chan_sel,
    input  logic [DATA_W-1:0] adc_data,
    output logic              rd_n,
    output logic              cs_n,
    output logic              latch_en,
    output logic [DATA_W-1:0] cap_data
);
    logic irq_fall;

    chan_pick_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_n    (irq_n),
        .irq_fall (irq_fall)
    );

    chan_pick_seq #(
        .NUM_READS (NUM_READS),
        .LOW_CYC   (LOW_CYC),
        .GAP_CYC   (GAP_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (irq_fall),
        .sel      (chan_sel),
        .rd_n     (rd_n),
        .cs_n     (cs_n),
        .latch_en (latch_en)
    );

    chan_pick_cap #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (latch_en),
        .din   (adc_data),
        .dout  (cap_data)
    );

    assert_start_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_fall) && $past(cs_n) && $past(rst_n)) |-> (!rd_n && !cs_n));
endmodule

// File: tb/chan_pick_demux_tb.sv
module chan_pick_demux_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LOW_CYC = 1;
    localparam int GAP_CYC = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_n = 1'b1;
    logic [1:0]  chan_sel = 2'b00;
    logic [11:0] adc_data = '0;
    logic        rd_n, cs_n, latch_en;
    logic [11:0] cap_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    chan_pick_demux u_dut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .chan_sel(chan_sel),
        .adc_data(adc_data), .rd_n(rd_n), .cs_n(cs_n),
        .latch_en(latch_en), .cap_data(cap_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] word_of(input int seed, input int pos);
        return 12'((seed * 12'h137) ^ (pos * 12'h2C5) ^ 12'h5A0);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One burst: drive the interrupt edge, model the converter bus, measure every strobe.
    task automatic run_burst(input int seed, input logic [1:0] sel,
                             input bit inject_irq, input bit change_sel);
        int reads = 0, latches = 0, latch_pos = -1, cs_bad = 0;
        int lo_run = 0, hi_run = 0, lo_bad = 0, gap_bad = 0, extra = 0;
        bit prev_rd = 1'b1, seen_cs = 1'b0, first_ok = 1'b0;
        @(negedge clk);
        chan_sel = sel;
        irq_n = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == 0) first_ok = (rd_n == 1'b0) && (cs_n == 1'b0);
            if (change_sel && i == 1) chan_sel = ~sel;
            if (inject_irq && i == 2) irq_n = 1'b1;
            if (inject_irq && i == 3) irq_n = 1'b0;
            if (!cs_n) seen_cs = 1'b1;
            if (!rd_n && cs_n) cs_bad++;
            if (!rd_n && prev_rd) begin
                if (reads > 0 && hi_run != GAP_CYC) gap_bad++;
                adc_data = word_of(seed, reads);
                reads++;
                lo_run = 0;
            end
            if (rd_n && !prev_rd) begin
                if (lo_run != LOW_CYC) lo_bad++;
                hi_run = 0;
            end
            if (!rd_n) lo_run++;
            else if (!cs_n) hi_run++;
            if (latch_en) begin
                latches++;
                latch_pos = reads - 1;
            end
            prev_rd = rd_n;
            if (seen_cs && cs_n) break;
        end
        check("R9 strobe one cycle after edge", int'(first_ok), 1);
        check("R1 strobe count", reads, 4);
        check("R2 strobe outside select", cs_bad, 0);
        check("R2 select released after burst", int'(cs_n), 1);
        check("R3 low width errors", lo_bad, 0);
        check("R3 gap width errors", gap_bad, 0);
        check("R4 latch pulses", latches, 1);
        check("R4 latch position", latch_pos, int'(sel));
        @(negedge clk);
        check("R5 captured word", int'(cap_data), int'(word_of(seed, int'(sel))));
        // Interrupt still low: nothing new must start.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!rd_n || !cs_n) extra++;
        end
        check("R7 no restart while low", extra, 0);
        check("R5 capture held", int'(cap_data), int'(word_of(seed, int'(sel))));
        irq_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R10 rd_n", int'(rd_n), 1);
        check("R10 cs_n", int'(cs_n), 1);
        check("R10 latch_en", int'(latch_en), 0);
        check("R10 cap_data", int'(cap_data), 0);
    endtask

    task automatic test_all_selects();
        for (int s = 0; s < 4; s++) run_burst(s + 1, 2'(s), 1'b0, 1'b0); // R1 R4 across codes
    endtask

    task automatic test_mid_burst_irq();
        run_burst(9, 2'b10, 1'b1, 1'b0); // R7: the extra fall is ignored
    endtask

    task automatic test_sel_change();
        run_burst(11, 2'b01, 1'b0, 1'b1); // R6: capture follows the code at the start
    endtask

    task automatic test_counter_restart();
        run_burst(13, 2'b11, 1'b0, 1'b0);
        run_burst(14, 2'b00, 1'b0, 1'b0); // R8: first word right after a full burst
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_all_selects();
        test_mid_burst_irq();
        test_sel_change();
        test_counter_restart();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule